// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a scratchpad split into 16 banks, each one 32-bit word wide. A group of 16 lanes presents a single access request. Each lane carries a word address and an active bit. Each bank can serve one word per clock. The block therefore splits the request into a sequence of cycles in which no bank is asked for two different words. Lanes that name the same word in the same cycle are served together by one fetch, and the data is broadcast to all of them. Same-word lanes are not counted as a conflict.

A request is accepted when the block is idle. While it is busy, it produces one grant cycle per clock. Each grant cycle gives the mask of lanes served, the per-bank enable and word address, and a flag on the final cycle. The request length is set by the most heavily loaded bank. A request whose lanes all fall in distinct banks, or all name one word, finishes in one cycle. A word stride of 2 takes 2 cycles, a stride of 8 takes 8, and a stride of 16 takes 16.

Top module: `bank_conflict_serializer`

## Requirements
- R1: After reset `busy`, `gnt_mask`, `gnt_last` and `bank_en` are all zero, and they stay zero whenever `busy` is low.
- R2: `req_ready` equals the inverse of `busy`. A request with `req_valid` high and `req_ready` high is taken at that clock edge. If any bit of `req_active` was set, `busy` is high in the following cycle. A request with no active lane starts no grant cycle and `busy` stays low.
- R3: While `busy` is high, `req_valid`, `req_active` and `req_addr` have no effect on the grant sequence in progress, and no new request is started.
- R4: Lane l drives its 16-bit word address on `req_addr[l*16 +: 16]`. Its bank is the address modulo 16, which is its low 4 bits. In a grant cycle `bank_en[b]` is high for every bank that has a pending lane. `bank_addr[b*16 +: 16]` then carries the single word that bank serves.
- R5: In each grant cycle, every bank serves the word of the lowest-numbered lane still pending in that bank.
- R6: Every pending lane whose address equals the word its bank serves is granted in that same cycle (broadcast).
- R7: Over one request, each active lane is granted in exactly one cycle, and an inactive lane is never granted.
- R8: The number of grant cycles equals the largest number of distinct words requested from any one bank. A conflict-free pattern or an all-same-address pattern takes one cycle.
- R9: `gnt_last` is high only in the final grant cycle of a request. `busy` is low in the cycle after it.
- R10: Every cycle with `busy` high grants at least one lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and will take a request |
| req_active | input | 16 | Per-lane active bits |
| req_addr | input | 256 | Per-lane 16-bit word addresses, lane l at bits l*16 +: 16 |
| busy | output | 1 | A request is being served; high exactly in grant cycles |
| gnt_mask | output | 16 | Lanes served in this cycle |
| gnt_last | output | 1 | This is the final grant cycle of the request |
| bank_en | output | 16 | Banks accessed in this cycle |
| bank_addr | output | 256 | Word served by each bank, bank b at bits b*16 +: 16 |

## Verification
If the pending-lane register held a wrong bit, the fault would appear at the ports in the very next grant cycle. A dropped lane would shorten the sequence and go missing from the union of grant masks. A lane that was never cleared would keep `busy` high past the expected cycle count. A stale bank pick would show up in the same cycle as a `bank_addr` that does not belong to the lowest pending lane of that bank. It would also show up as a `gnt_mask` that misses a broadcast partner. The bench therefore compares every output on every clock against a behavioural model of the pending set. It also compares the total cycle count against the per-bank distinct-word count worked out when the request is issued.

// File: rtl/bksr_pkg.sv
package bksr_pkg;

   // Serving state of the request register
   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_SERVE = 1'b1
   } bksr_state_e;

   // Bank index width; a single bank still gets a one-bit field
   function automatic int unsigned bank_bits(input int unsigned banks);
      return (banks > 1) ? $clog2(banks) : 1;
   endfunction

endpackage

// File: rtl/bksr_req_store.sv
module bksr_req_store
   import bksr_pkg::*;
#(
   parameter int LANES = 16,
   parameter int AW    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      accept,
   input  logic [LANES-1:0]          active_in,
   input  logic [LANES-1:0][AW-1:0]  addr_in,
   input  logic [LANES-1:0]          gnt,
   output logic                      busy,
   output logic [LANES-1:0]          pend_q,
   output logic [LANES-1:0][AW-1:0]  addr_q
);

   bksr_state_e      state_q;
   logic [LANES-1:0] pend_left;

   assign pend_left = pend_q & ~gnt;
   assign busy      = (state_q == ST_SERVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
      end else if (accept) begin
         pend_q  <= active_in;
         state_q <= (|active_in) ? ST_SERVE : ST_IDLE;
      end else if (state_q == ST_SERVE) begin
         pend_q  <= pend_left;
         state_q <= (|pend_left) ? ST_SERVE : ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (accept) begin
         addr_q <= addr_in;
      end
   end

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q)); // R3

   AST_PEND_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((pend_q & ~$past(pend_q)) == '0)); // R7

endmodule

// File: rtl/bksr_bank_pick.sv
module bksr_bank_pick #(
   parameter int LANES   = 16,
   parameter int AW      = 16,
   parameter int BANKS   = 16,
   parameter int BANK_ID = 0
) (
   input  logic [LANES-1:0]          pend,
   input  logic [LANES-1:0][AW-1:0]  addr,
   output logic                      en,
   output logic [AW-1:0]             word
);

   localparam int BW = bksr_pkg::bank_bits(BANKS);

   logic [LANES-1:0] hit;

   generate
      if (BANKS == 1) begin : g_single
         assign hit = pend;
      end else begin : g_multi
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign hit[l] = pend[l] && (addr[l][BW-1:0] == BW'(BANK_ID));
         end
      end
   endgenerate

   // Scan downward so the lowest pending lane is written last and wins
   always_comb begin
      word = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
         if (hit[l]) word = addr[l];
      end
   end

   assign en = |hit;

endmodule

// File: rtl/bksr_lane_match.sv
module bksr_lane_match #(
   parameter int LANES = 16,
   parameter int AW    = 16,
   parameter int BANKS = 16
) (
   input  logic [LANES-1:0]          pend,
   input  logic [LANES-1:0][AW-1:0]  addr,
   input  logic [BANKS-1:0][AW-1:0]  bank_word,
   output logic [LANES-1:0]          gnt
);

   localparam int BW = bksr_pkg::bank_bits(BANKS);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         if (BANKS == 1) begin : g_single
            assign gnt[l] = pend[l] && (addr[l] == bank_word[0]);
         end else begin : g_multi
            logic [BW-1:0] bsel;
            assign bsel   = addr[l][BW-1:0];
            assign gnt[l] = pend[l] && (addr[l] == bank_word[bsel]);
         end
      end
   endgenerate

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer #(
   parameter int LANES = 16,
   parameter int BANKS = 16,
   parameter int AW    = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [LANES-1:0]      req_active,
   input  logic [LANES*AW-1:0]   req_addr,
   output logic                  busy,
   output logic [LANES-1:0]      gnt_mask,
   output logic                  gnt_last,
   output logic [BANKS-1:0]      bank_en,
   output logic [BANKS*AW-1:0]   bank_addr
);

   localparam int BW = bksr_pkg::bank_bits(BANKS);

   generate
      if ((BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
         $error("BANKS must be a power of two");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least one");
      end
      if (AW < BW) begin : g_bad_aw
         $error("AW must cover the bank index");
      end
   endgenerate

   logic [LANES-1:0][AW-1:0] addr_in;
   logic [LANES-1:0][AW-1:0] addr_q;
   logic [LANES-1:0]         pend_q;
   logic [BANKS-1:0][AW-1:0] bank_word;
   logic                     accept;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_unpack
         assign addr_in[l] = req_addr[l*AW +: AW];
      end
   endgenerate

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   bksr_req_store #(.LANES(LANES), .AW(AW)) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .active_in (req_active),
      .addr_in   (addr_in),
      .gnt       (gnt_mask),
      .busy      (busy),
      .pend_q    (pend_q),
      .addr_q    (addr_q)
   );

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         bksr_bank_pick #(
            .LANES(LANES), .AW(AW), .BANKS(BANKS), .BANK_ID(b)
         ) pick_i (
            .pend (pend_q),
            .addr (addr_q),
            .en   (bank_en[b]),
            .word (bank_word[b])
         );
         assign bank_addr[b*AW +: AW] = bank_word[b];
      end
   endgenerate

   bksr_lane_match #(.LANES(LANES), .AW(AW), .BANKS(BANKS)) match_i (
      .pend      (pend_q),
      .addr      (addr_q),
      .bank_word (bank_word),
      .gnt       (gnt_mask)
   );

   assign gnt_last = busy && ((pend_q & ~gnt_mask) == '0);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (gnt_mask == '0 && bank_en == '0 && !gnt_last)); // R1

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && |req_active) |=> busy); // R2

   AST_GRANT_IN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_mask & ~pend_q) == '0)); // R7

   AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (gnt_mask != '0)); // R10

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && gnt_last) |=> !busy); // R9

   AST_NOT_LAST_GOES_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !gnt_last) |=> busy); // R9

   generate
      if (BANKS > 1) begin : g_word_chk
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            AST_LANE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
               gnt_mask[l] |-> (bank_en[addr_q[l][BW-1:0]] &&
                                bank_word[addr_q[l][BW-1:0]] == addr_q[l])); // R4
         end
      end
   endgenerate

endmodule

// File: tb/bank_conflict_serializer_tb_top.sv
`timescale 1ns/1ps
module bank_conflict_serializer_tb_top;

   localparam int L  = 16;
   localparam int NB = 16;
   localparam int AW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [L-1:0]    req_active = '0;
   logic [L*AW-1:0] req_addr = '0;
   logic            busy;
   logic [L-1:0]    gnt_mask;
   logic            gnt_last;
   logic [NB-1:0]   bank_en;
   logic [NB*AW-1:0] bank_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int unsigned stim[L];
   int unsigned m_addr[L];
   logic [L-1:0] m_pend;

   always #2.5 clk = ~clk;

   bank_conflict_serializer #(.LANES(L), .BANKS(NB), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_active(req_active), .req_addr(req_addr), .busy(busy),
      .gnt_mask(gnt_mask), .gnt_last(gnt_last), .bank_en(bank_en),
      .bank_addr(bank_addr)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint unsigned act, input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int distinct_max(input logic [L-1:0] act);
      int cnt[NB];
      int mx = 0;
      for (int b = 0; b < NB; b++) cnt[b] = 0;
      for (int l = 0; l < L; l++) begin
         bit seen = 1'b0;
         if (!act[l]) continue;
         for (int j = 0; j < l; j++)
            if (act[j] && stim[j] == stim[l]) seen = 1'b1;
         if (!seen) cnt[stim[l] % NB]++;
      end
      for (int b = 0; b < NB; b++) if (cnt[b] > mx) mx = cnt[b];
      return mx;
   endfunction

   // Called at a negedge; issues stim[] with mask act and follows it to the end
   task automatic run_req(input logic [L-1:0] act, input bit poke, input string name);
      int exp_cycles;
      int cycles = 0;
      logic [L-1:0] seen_gnt = '0;
      chk(req_ready == 1'b1 && busy == 1'b0, "R2", {name, " ready before issue"},
          {req_ready, busy}, 2'b10);
      for (int l = 0; l < L; l++) req_addr[l*AW +: AW] = AW'(stim[l]);
      req_active = act;
      req_valid  = 1'b1;
      exp_cycles = distinct_max(act);
      for (int l = 0; l < L; l++) m_addr[l] = stim[l] & 32'hFFFF;
      m_pend = act;
      @(negedge clk);
      req_valid = 1'b0;
      while (m_pend != '0) begin
         bit           claimed[NB];
         int unsigned  word[NB];
         logic [L-1:0] eg = '0;
         logic [NB-1:0] een = '0;
         for (int b = 0; b < NB; b++) begin claimed[b] = 1'b0; word[b] = 0; end
         for (int l = 0; l < L; l++) begin
            if (m_pend[l]) begin
               int b = int'(m_addr[l] % NB);
               if (!claimed[b]) begin claimed[b] = 1'b1; word[b] = m_addr[l]; een[b] = 1'b1; end
               if (m_addr[l] == word[b]) eg[l] = 1'b1;
            end
         end
         chk(busy == 1'b1, "R2", {name, " busy"}, busy, 1);
         chk(gnt_mask == eg, "R6", {name, " gnt_mask"}, gnt_mask, eg);
         chk(bank_en == een, "R4", {name, " bank_en"}, bank_en, een);
         for (int b = 0; b < NB; b++)
            if (een[b])
               chk(bank_addr[b*AW +: AW] == AW'(word[b]), "R5", {name, " bank word"},
                   bank_addr[b*AW +: AW], word[b]);
         chk(gnt_last == ((m_pend & ~eg) == '0), "R9", {name, " gnt_last"},
             gnt_last, (m_pend & ~eg) == '0);
         chk((gnt_mask & seen_gnt) == '0, "R7", {name, " lane granted twice"},
             gnt_mask & seen_gnt, 0);
         seen_gnt |= gnt_mask;
         m_pend &= ~eg;
         cycles++;
         if (poke) begin
            // R3: offer a conflicting request mid-sequence
            req_valid  = 1'b1;
            req_active = '1;
            for (int l = 0; l < L; l++) req_addr[l*AW +: AW] = AW'(l * 16 + 3);
         end
         if (cycles > L + 2) begin
            chk(1'b0, "R8", {name, " runaway sequence"}, cycles, exp_cycles);
            break;
         end
         @(negedge clk);
         req_valid = 1'b0;
      end
      chk(busy == 1'b0 && gnt_mask == '0 && bank_en == '0, "R1", {name, " quiet after end"},
          {busy, gnt_mask}, 0);
      chk(cycles == exp_cycles, "R8", {name, " cycle count"}, cycles, exp_cycles);
      chk(seen_gnt == act, "R7", {name, " union of grants"}, seen_gnt, act);
      if (poke)
         chk(busy == 1'b0, "R3", {name, " request while busy ignored"}, busy, 0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && gnt_mask == 0 && gnt_last == 0 && bank_en == 0, "R1",
          "reset outputs", {busy, gnt_mask, gnt_last, bank_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int l = 0; l < L; l++) stim[l] = 32 + l;
      run_req('1, 1'b0, "linear");                 // R8 one cycle
      for (int l = 0; l < L; l++) stim[l] = 64 + ((l * 5) % 16);
      run_req('1, 1'b0, "permuted");               // R8 one cycle
      for (int l = 0; l < L; l++) stim[l] = l * 2;
      run_req('1, 1'b0, "stride2");                // R8 two cycles
      for (int l = 0; l < L; l++) stim[l] = l * 8;
      run_req('1, 1'b0, "stride8");                // R8 eight cycles
      for (int l = 0; l < L; l++) stim[l] = l * 16 + 7;
      run_req('1, 1'b1, "stride16_poke");          // R3, sixteen cycles
      for (int l = 0; l < L; l++) stim[l] = 500;
      run_req('1, 1'b0, "broadcast");              // R6 one cycle
      for (int l = 0; l < L; l++) stim[l] = (l % 2 == 0) ? 16 * (l % 3) : 5;
      run_req(16'hA5C3, 1'b0, "mixed_partial");    // R5 R7

      // R2: request with no active lane never starts a sequence
      for (int l = 0; l < L; l++) req_addr[l*AW +: AW] = AW'(l);
      req_active = '0;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b0 && gnt_mask == '0, "R2", "empty request", {busy, gnt_mask}, 0);

      for (int t = 0; t < 60; t++) begin
         for (int l = 0; l < L; l++) stim[l] = $urandom_range(0, 63);
         run_req(L'($urandom), t[0], "random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule